// File: doc/BRIEF.md
# 8-bit ALU with condition code update

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It takes two byte operands, a carry-in, the current condition code register and an operation select, and it returns the byte result together with the next value of the half-carry (H), negative (N), zero (Z), overflow (V) and carry (C) flags. Each flag also has its own write enable. The enable is high only when the selected operation actually updates that flag.

The block is purely combinational. The surrounding datapath merges the five flag outputs into its condition code register under their enables, and it decides whether the result is written to a destination. Compare, bit test and test produce a result that is normally discarded. Instruction decode, the 16-bit paired-accumulator operations and the multiplier sit outside this block.

Every operation follows its own fixed plan for each flag. A flag can be computed, forced to 0, forced to 1, or left alone. When a flag is left alone, its value output equals the incoming register bit, so a consumer can use either the enables or the values on their own.

Top module: `alu8_ccr_unit`

## Requirements
- R1: `ccr_in` carries H at bit 5, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Bits 7, 6 and 4 have no effect. `op_sel` is encoded as follows: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 negate, 6 AND, 7 OR, 8 XOR, 9 bit test, 10 load/pass, 11 complement, 12 clear, 13 test, 14 increment, 15 decrement, 16 arithmetic shift left, 17 arithmetic shift right, 18 logical shift right, 19 rotate left, 20 rotate right, 21 decimal adjust. Codes 22 to 31 are unused.
- R2: Add returns `opa+opb`, and add with carry returns `opa+opb+carry_in`, both modulo 256. Both write all five flags. H is the carry out of bit 3. C is the carry out of bit 7. V is set when the two operands share a sign and the result sign differs from it.
- R3: Subtract and compare return `opa-opb`, and subtract with carry returns `opa-opb-carry_in`. Negate returns `0-opa`. All four write N, Z, V and C and leave H unwritten. C is the borrow. V is set when the operand signs differ and the result sign differs from `opa`. For negate, C=1 exactly when the result is nonzero, and V=1 exactly when `opa` is 0x80.
- R4: AND, OR, XOR, bit test and load/pass write N and Z, force V to 0, and leave H and C unwritten.
- R5: Clear returns 0 and forces N=0, Z=1, V=0 and C=0. H is unwritten.
- R6: Complement returns `~opa`, writes N and Z, forces V=0 and forces C=1.
- R7: Test returns `opa`, writes N and Z, and forces V=0 and C=0.
- R8: Increment and decrement return `opa±1`. They write N, Z and V, with V set for 0x7F on increment and for 0x80 on decrement. C and H are never written.
- R9: For the arithmetic left, arithmetic right and logical right shifts, C takes the bit shifted out. Arithmetic right keeps bit 7, and logical right inserts 0, which makes N=0. For every shift and rotate, V equals N XOR C of the new values.
- R10: Rotate left and rotate right move `carry_in` into the vacated bit and the bit that drops out into C.
- R11: Decimal adjust adds 0x06 when H (`ccr_in` bit 5) is set or the low nibble exceeds 9. It adds 0x60 when C (`ccr_in` bit 0) is set, when the high nibble exceeds 9, or when the high nibble exceeds 8 and the low nibble exceeds 9. C becomes the old C OR the upper correction. N and Z are written, and H and V are not.
- R12: Any flag that is not written has its write enable low and its value equal to its `ccr_in` bit. Unused op codes return `opa` and write no flag.
- R13: Whenever Z is written it equals (result==0), and whenever N is written it equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation select |
| opa | input | 8 | First operand (accumulator) |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Carry used by add/subtract with carry and by rotates |
| ccr_in | input | 8 | Current condition code register |
| result | output | 8 | Operation result |
| h_nxt | output | 1 | Next half-carry flag |
| n_nxt | output | 1 | Next negative flag |
| z_nxt | output | 1 | Next zero flag |
| v_nxt | output | 1 | Next overflow flag |
| c_nxt | output | 1 | Next carry flag |
| h_wr | output | 1 | H write enable |
| n_wr | output | 1 | N write enable |
| z_wr | output | 1 | Z write enable |
| v_wr | output | 1 | V write enable |
| c_wr | output | 1 | C write enable |

## Verification
The hardest cases to reach are the ones where a flag must keep its incoming value while the operation computes a conflicting one. Examples are increment with C already set, or a subtract whose low nibble would generate a half carry while H=1 arrives on `ccr_in`. A plain sweep with zero flags cannot tell "unwritten" from "written as 0". The vector table therefore preloads `ccr_in` with flags opposite to the values the operation would produce. The random sweep also drives random `ccr_in` bytes. Decimal adjust is reached with operands and H/C combinations that trigger each correction on its own and both together, including the high-nibble-9 case that only triggers through a low nibble above 9.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW     = 8;
    localparam int HALF_W = DW / 2;
    localparam int CCR_W  = 8;
    localparam int CCR_H  = 5;
    localparam int CCR_I  = 4;
    localparam int CCR_N  = 3;
    localparam int CCR_Z  = 2;
    localparam int CCR_V  = 1;
    localparam int CCR_C  = 0;
    localparam int NFLAG  = 5;

    // index of each flag inside the 5-bit flag vectors
    localparam int FI_H = 4;
    localparam int FI_N = 3;
    localparam int FI_Z = 2;
    localparam int FI_V = 1;
    localparam int FI_C = 0;

    typedef enum logic [4:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_CMP = 5'd4,  OP_NEG = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
        OP_XOR = 5'd8,  OP_BIT = 5'd9,  OP_LD  = 5'd10, OP_COM = 5'd11,
        OP_CLR = 5'd12, OP_TST = 5'd13, OP_INC = 5'd14, OP_DEC = 5'd15,
        OP_ASL = 5'd16, OP_ASR = 5'd17, OP_LSR = 5'd18, OP_ROL = 5'd19,
        OP_ROR = 5'd20, OP_DAA = 5'd21
    } alu_op_e;

    // how a flag is produced by an operation
    typedef enum logic [1:0] {
        FS_KEEP = 2'd0,
        FS_CALC = 2'd1,
        FS_ZERO = 2'd2,
        FS_ONE  = 2'd3
    } fsrc_e;

    typedef struct packed {
        fsrc_e h;
        fsrc_e n;
        fsrc_e z;
        fsrc_e v;
        fsrc_e c;
    } flag_plan_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          ci;
        logic          sub;
    } addsub_req_t;

    typedef enum logic [2:0] {
        RS_ADDER = 3'd0,
        RS_LOGIC = 3'd1,
        RS_SHIFT = 3'd2,
        RS_DAA   = 3'd3,
        RS_PASS  = 3'd4
    } res_src_e;

    function automatic logic is_arith(alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
            OP_NEG, OP_INC, OP_DEC: is_arith = 1'b1;
            default:                is_arith = 1'b0;
        endcase
    endfunction

    function automatic logic is_shift(alu_op_e op);
        case (op)
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: is_shift = 1'b1;
            default:                                is_shift = 1'b0;
        endcase
    endfunction

    function automatic logic is_logic(alu_op_e op);
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_BIT, OP_LD,
            OP_COM, OP_CLR, OP_TST: is_logic = 1'b1;
            default:                is_logic = 1'b0;
        endcase
    endfunction

    function automatic res_src_e res_source(alu_op_e op);
        if (is_arith(op))      res_source = RS_ADDER;
        else if (is_logic(op)) res_source = RS_LOGIC;
        else if (is_shift(op)) res_source = RS_SHIFT;
        else if (op == OP_DAA) res_source = RS_DAA;
        else                   res_source = RS_PASS;
    endfunction

    // per-operation flag plan
    function automatic flag_plan_t plan_for(alu_op_e op);
        flag_plan_t p;
        p = '{h: FS_KEEP, n: FS_KEEP, z: FS_KEEP, v: FS_KEEP, c: FS_KEEP};
        case (op)
            OP_ADD, OP_ADC:
                p = '{h: FS_CALC, n: FS_CALC, z: FS_CALC, v: FS_CALC, c: FS_CALC};
            OP_SUB, OP_SBC, OP_CMP, OP_NEG:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_CALC, c: FS_CALC};
            OP_AND, OP_OR, OP_XOR, OP_BIT, OP_LD:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_ZERO, c: FS_KEEP};
            OP_COM:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_ZERO, c: FS_ONE};
            OP_CLR:
                p = '{h: FS_KEEP, n: FS_ZERO, z: FS_ONE, v: FS_ZERO, c: FS_ZERO};
            OP_TST:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_ZERO, c: FS_ZERO};
            OP_INC, OP_DEC:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_CALC, c: FS_KEEP};
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_CALC, c: FS_CALC};
            OP_DAA:
                p = '{h: FS_KEEP, n: FS_CALC, z: FS_CALC, v: FS_KEEP, c: FS_CALC};
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int HW = HALF_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         half,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         ci_eff;
    logic [W:0]   full;
    logic [HW:0]  low;

    always_comb begin
        b_eff  = sub ? ~b : b;
        ci_eff = sub ? ~ci : ci;
        full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};
        low    = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, ci_eff};
        sum    = full[W-1:0];
        half   = low[HW];
        carry  = sub ? ~full[W] : full[W];
        ovf    = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);
    always_comb begin
        case (op)
            OP_AND, OP_BIT: res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_COM:         res = ~a;
            OP_CLR:         res = '0;
            default:        res = a;   // load/pass and test
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_ASL: begin res = {a[DW-2:0], 1'b0};     cout = a[DW-1]; end
            OP_ASR: begin res = {a[DW-1], a[DW-1:1]};  cout = a[0];    end
            OP_LSR: begin res = {1'b0, a[DW-1:1]};     cout = a[0];    end
            OP_ROL: begin res = {a[DW-2:0], cin};      cout = a[DW-1]; end
            OP_ROR: begin res = {cin, a[DW-1:1]};      cout = a[0];    end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          h_in,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          c_out
);
    localparam logic [HALF_W-1:0] NIB_MAX = HALF_W'(9);
    localparam logic [HALF_W-1:0] NIB_FIX = HALF_W'(6);

    logic [HALF_W-1:0] lo, hi;
    logic              lo_fix, hi_fix;

    always_comb begin
        lo     = a[HALF_W-1:0];
        hi     = a[DW-1:HALF_W];
        lo_fix = h_in || (lo > NIB_MAX);
        hi_fix = c_in || (hi > NIB_MAX) || ((hi > (NIB_MAX - 1'b1)) && (lo > NIB_MAX));
        res    = a + {(hi_fix ? NIB_FIX : '0), (lo_fix ? NIB_FIX : '0)};
        c_out  = c_in | hi_fix;
    end
endmodule

// File: rtl/alu8_flag_sel.sv
module alu8_flag_sel
    import alu8_pkg::*;
(
    input  fsrc_e src,
    input  logic  calc,
    input  logic  keep,
    output logic  we,
    output logic  val
);
    always_comb begin
        case (src)
            FS_CALC: begin we = 1'b1; val = calc;  end
            FS_ZERO: begin we = 1'b1; val = 1'b0;  end
            FS_ONE:  begin we = 1'b1; val = 1'b1;  end
            default: begin we = 1'b0; val = keep;  end
        endcase
    end
endmodule

// File: rtl/alu8_ccr_unit.sv
module alu8_ccr_unit
    import alu8_pkg::*;
(
    input  logic [4:0]       op_sel,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic             carry_in,
    input  logic [CCR_W-1:0] ccr_in,
    output logic [DW-1:0]    result,
    output logic             h_nxt,
    output logic             n_nxt,
    output logic             z_nxt,
    output logic             v_nxt,
    output logic             c_nxt,
    output logic             h_wr,
    output logic             n_wr,
    output logic             z_wr,
    output logic             v_wr,
    output logic             c_wr
);
    alu_op_e     op;
    flag_plan_t  plan;
    res_src_e    rsel;
    addsub_req_t areq;

    logic [DW-1:0] add_sum, log_res, sh_res, daa_res;
    logic          add_half, add_carry, add_ovf, sh_c, daa_c;
    logic          ccr_unused;

    logic [NFLAG-1:0] calc_v, keep_v, we_v, val_v;
    fsrc_e            src_v [NFLAG];

    assign op         = alu_op_e'(op_sel);
    assign plan       = plan_for(op);
    assign rsel       = res_source(op);
    assign ccr_unused = ^{ccr_in[CCR_W-1:CCR_H+1], ccr_in[CCR_I]};

    // operand steering for the shared adder
    always_comb begin
        areq = '{a: opa, b: opb, ci: 1'b0, sub: 1'b0};
        case (op)
            OP_ADC:         areq.ci  = carry_in;
            OP_SUB, OP_CMP: areq.sub = 1'b1;
            OP_SBC: begin   areq.sub = 1'b1; areq.ci = carry_in; end
            OP_NEG: begin   areq.a = '0; areq.b = opa; areq.sub = 1'b1; end
            OP_INC:         areq.b = DW'(1);
            OP_DEC: begin   areq.b = DW'(1); areq.sub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.W(DW), .HW(HALF_W)) u_add (
        .a(areq.a), .b(areq.b), .ci(areq.ci), .sub(areq.sub),
        .sum(add_sum), .half(add_half), .carry(add_carry), .ovf(add_ovf)
    );

    alu8_logic u_log (.op(op), .a(opa), .b(opb), .res(log_res));

    alu8_shift u_sh (.op(op), .a(opa), .cin(carry_in), .res(sh_res), .cout(sh_c));

    alu8_daa u_daa (
        .a(opa), .h_in(ccr_in[CCR_H]), .c_in(ccr_in[CCR_C]),
        .res(daa_res), .c_out(daa_c)
    );

    always_comb begin
        case (rsel)
            RS_ADDER: result = add_sum;
            RS_LOGIC: result = log_res;
            RS_SHIFT: result = sh_res;
            RS_DAA:   result = daa_res;
            default:  result = opa;
        endcase
    end

    // computed flag candidates
    always_comb begin
        calc_v[FI_H] = add_half;
        calc_v[FI_N] = result[DW-1];
        calc_v[FI_Z] = ~|result;
        if (rsel == RS_SHIFT)    calc_v[FI_C] = sh_c;
        else if (rsel == RS_DAA) calc_v[FI_C] = daa_c;
        else                     calc_v[FI_C] = add_carry;
        calc_v[FI_V] = (rsel == RS_SHIFT) ? (result[DW-1] ^ sh_c) : add_ovf;
    end

    assign keep_v = {ccr_in[CCR_H], ccr_in[CCR_N], ccr_in[CCR_Z], ccr_in[CCR_V], ccr_in[CCR_C]};
    assign src_v[FI_H] = plan.h;
    assign src_v[FI_N] = plan.n;
    assign src_v[FI_Z] = plan.z;
    assign src_v[FI_V] = plan.v;
    assign src_v[FI_C] = plan.c;

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        alu8_flag_sel u_sel (
            .src(src_v[gi]), .calc(calc_v[gi]), .keep(keep_v[gi]),
            .we(we_v[gi]), .val(val_v[gi])
        );
    end

    assign {h_nxt, n_nxt, z_nxt, v_nxt, c_nxt} = val_v;
    assign {h_wr,  n_wr,  z_wr,  v_wr,  c_wr}  = we_v;

    // checks on the combined outputs
    always_comb begin
        if (z_wr) begin
            a_r13_zero_tracks: assert (z_nxt == (result == '0))
                else $error("Z does not match result");
        end
        if (n_wr) begin
            a_r13_neg_tracks: assert (n_nxt == result[DW-1])
                else $error("N does not match result sign");
        end
        if (!h_wr) begin
            a_r12_h_held: assert (h_nxt == ccr_in[CCR_H])
                else $error("unwritten H changed");
        end
        if (!c_wr) begin
            a_r12_c_held: assert (c_nxt == ccr_in[CCR_C])
                else $error("unwritten C changed");
        end
        if (is_shift(op)) begin
            a_r9_shift_v: assert (v_wr && (v_nxt == (n_nxt ^ c_nxt)))
                else $error("shift V is not N xor C");
        end
        if (op == OP_SUB || op == OP_SBC || op == OP_CMP || op == OP_NEG) begin
            a_r3_no_half: assert (!h_wr)
                else $error("subtract class wrote H");
        end
        if (op == OP_INC || op == OP_DEC) begin
            a_r8_carry_untouched: assert (!c_wr)
                else $error("inc/dec wrote C");
        end
        if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_BIT || op == OP_LD) begin
            a_r4_logic_v_clear: assert (v_wr && !v_nxt && !c_wr)
                else $error("logic op flag plan broken");
        end
    end

endmodule

// File: tb/alu8_ccr_unit_test.sv
module alu8_ccr_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 28;
    localparam int RAND_PER   = 100;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cin;
        logic [7:0] fin;
        logic [7:0] res;
        logic [4:0] we;   // H N Z V C
        logic [4:0] val;  // H N Z V C
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{5'd0,  8'h3A, 8'h48, 1'b0, 8'h00, 8'h82, 5'b11111, 5'b11010}, // R2 half, overflow
        '{5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 8'h00, 5'b11111, 5'b10101}, // R2 carry, zero
        '{5'd1,  8'h10, 8'h20, 1'b1, 8'h00, 8'h31, 5'b11111, 5'b00000}, // R2 adc
        '{5'd2,  8'h10, 8'h20, 1'b0, 8'h20, 8'hF0, 5'b01111, 5'b11001}, // R3 borrow, H held
        '{5'd2,  8'h80, 8'h01, 1'b0, 8'h00, 8'h7F, 5'b01111, 5'b00010}, // R3 overflow
        '{5'd3,  8'h05, 8'h05, 1'b1, 8'h00, 8'hFF, 5'b01111, 5'b01001}, // R3 sbc
        '{5'd4,  8'h42, 8'h42, 1'b0, 8'h00, 8'h00, 5'b01111, 5'b00100}, // R3 cmp
        '{5'd5,  8'h80, 8'h00, 1'b0, 8'h00, 8'h80, 5'b01111, 5'b01011}, // R3 neg 0x80
        '{5'd5,  8'h00, 8'h00, 1'b0, 8'h01, 8'h00, 5'b01111, 5'b00100}, // R3 neg zero
        '{5'd6,  8'hF0, 8'h3C, 1'b0, 8'h01, 8'h30, 5'b01110, 5'b00001}, // R4 and, C held
        '{5'd9,  8'h0F, 8'hF0, 1'b0, 8'h00, 8'h00, 5'b01110, 5'b00100}, // R4 bit
        '{5'd7,  8'h81, 8'h02, 1'b0, 8'h02, 8'h83, 5'b01110, 5'b01000}, // R4 or, V cleared
        '{5'd8,  8'hFF, 8'h0F, 1'b0, 8'h00, 8'hF0, 5'b01110, 5'b01000}, // R4 xor
        '{5'd10, 8'h80, 8'h00, 1'b0, 8'h00, 8'h80, 5'b01110, 5'b01000}, // R4 load
        '{5'd12, 8'h77, 8'h00, 1'b0, 8'h2B, 8'h00, 5'b01111, 5'b10100}, // R5 clear
        '{5'd11, 8'h55, 8'h00, 1'b0, 8'h00, 8'hAA, 5'b01111, 5'b01001}, // R6 complement
        '{5'd13, 8'h00, 8'h00, 1'b0, 8'h03, 8'h00, 5'b01111, 5'b00100}, // R7 test
        '{5'd14, 8'h7F, 8'h00, 1'b0, 8'h01, 8'h80, 5'b01110, 5'b01011}, // R8 inc 7F
        '{5'd15, 8'h80, 8'h00, 1'b0, 8'h00, 8'h7F, 5'b01110, 5'b00010}, // R8 dec 80
        '{5'd16, 8'h81, 8'h00, 1'b0, 8'h00, 8'h02, 5'b01111, 5'b00011}, // R9 asl
        '{5'd18, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 5'b01111, 5'b00111}, // R9 lsr
        '{5'd17, 8'h81, 8'h00, 1'b0, 8'h00, 8'hC0, 5'b01111, 5'b01001}, // R9 asr
        '{5'd19, 8'h80, 8'h00, 1'b1, 8'h00, 8'h01, 5'b01111, 5'b00011}, // R10 rol
        '{5'd20, 8'h01, 8'h00, 1'b1, 8'h00, 8'h80, 5'b01111, 5'b01001}, // R10 ror
        '{5'd21, 8'h3C, 8'h00, 1'b0, 8'h00, 8'h42, 5'b01101, 5'b00000}, // R11 low fix
        '{5'd21, 8'h9A, 8'h00, 1'b0, 8'h00, 8'h00, 5'b01101, 5'b00101}, // R11 both fixes
        '{5'd21, 8'h30, 8'h00, 1'b0, 8'h20, 8'h36, 5'b01101, 5'b10000}, // R11 H driven
        '{5'd31, 8'h5A, 8'h00, 1'b0, 8'h2F, 8'h5A, 5'b00000, 5'b11111}  // R12 unused code
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_sel = '0;
    logic [7:0] opa = '0, opb = '0, ccr_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       h_nxt, n_nxt, z_nxt, v_nxt, c_nxt;
    logic       h_wr, n_wr, z_wr, v_wr, c_wr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_ccr_unit uut (
        .op_sel(op_sel), .opa(opa), .opb(opb), .carry_in(carry_in), .ccr_in(ccr_in),
        .result(result),
        .h_nxt(h_nxt), .n_nxt(n_nxt), .z_nxt(z_nxt), .v_nxt(v_nxt), .c_nxt(c_nxt),
        .h_wr(h_wr), .n_wr(n_wr), .z_wr(z_wr), .v_wr(v_wr), .c_wr(c_wr)
    );

    function automatic string req_of(logic [4:0] op);
        case (op)
            5'd0, 5'd1:                      return "R2";
            5'd2, 5'd3, 5'd4, 5'd5:          return "R3";
            5'd6, 5'd7, 5'd8, 5'd9, 5'd10:   return "R4";
            5'd12:                           return "R5";
            5'd11:                           return "R6";
            5'd13:                           return "R7";
            5'd14, 5'd15:                    return "R8";
            5'd16, 5'd17, 5'd18:             return "R9";
            5'd19, 5'd20:                    return "R10";
            5'd21:                           return "R11";
            default:                         return "R12";
        endcase
    endfunction

    // reference model written from the requirements: {res, we, val}
    function automatic logic [17:0] ref_model(logic [4:0] op, logic [7:0] a, logic [7:0] b,
                                              logic cin, logic [7:0] fin);
        logic [7:0] r;
        logic [4:0] we, val;
        logic [8:0] wide;
        logic [4:0] nib;
        logic h, v, c, hf, lf;
        r   = a;
        we  = 5'b00000;
        val = {fin[5], fin[3], fin[2], fin[1], fin[0]};
        h = val[4]; v = val[1]; c = val[0];
        case (op)
            5'd0, 5'd1: begin
                wide = {1'b0, a} + {1'b0, b} + ((op == 5'd1) ? 9'(cin) : 9'd0);
                nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + ((op == 5'd1) ? 5'(cin) : 5'd0);
                r = wide[7:0]; h = nib[4]; c = wide[8];
                v = (a[7] == b[7]) && (r[7] != a[7]);
                we = 5'b11111;
            end
            5'd2, 5'd3, 5'd4: begin
                wide = {1'b0, a} - {1'b0, b} - ((op == 5'd3) ? 9'(cin) : 9'd0);
                r = wide[7:0]; c = wide[8];
                v = (a[7] != b[7]) && (r[7] != a[7]);
                we = 5'b01111;
            end
            5'd5: begin
                r = 8'd0 - a; c = (a != 0); v = (a == 8'h80); we = 5'b01111;
            end
            5'd6, 5'd9: begin r = a & b; v = 0; we = 5'b01110; end
            5'd7:       begin r = a | b; v = 0; we = 5'b01110; end
            5'd8:       begin r = a ^ b; v = 0; we = 5'b01110; end
            5'd10:      begin r = a;     v = 0; we = 5'b01110; end
            5'd11:      begin r = ~a; v = 0; c = 1; we = 5'b01111; end
            5'd12:      begin r = 0;  v = 0; c = 0; we = 5'b01111; end
            5'd13:      begin r = a;  v = 0; c = 0; we = 5'b01111; end
            5'd14:      begin r = a + 1; v = (a == 8'h7F); we = 5'b01110; end
            5'd15:      begin r = a - 1; v = (a == 8'h80); we = 5'b01110; end
            5'd16, 5'd17, 5'd18, 5'd19, 5'd20: begin
                case (op)
                    5'd16:   begin r = a << 1;             c = a[7]; end
                    5'd17:   begin r = {a[7], a[7:1]};     c = a[0]; end
                    5'd18:   begin r = a >> 1;             c = a[0]; end
                    5'd19:   begin r = {a[6:0], cin};      c = a[7]; end
                    default: begin r = {cin, a[7:1]};      c = a[0]; end
                endcase
                v = r[7] ^ c; we = 5'b01111;
            end
            5'd21: begin
                lf = fin[5] || (a[3:0] > 4'd9);
                hf = fin[0] || (a[7:4] > 4'd9) || ((a[7:4] > 4'd8) && (a[3:0] > 4'd9));
                r  = a + (lf ? 8'h06 : 8'h00) + (hf ? 8'h60 : 8'h00);
                c  = fin[0] | hf;
                we = 5'b01101;
            end
            default: ;
        endcase
        if (we[4]) val[4] = h;
        if (we[3]) val[3] = r[7];
        if (we[2]) val[2] = (r == 0);
        if (we[1]) val[1] = v;
        if (we[0]) val[0] = c;
        return {r, we, val};
    endfunction

    task automatic run_one(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                           input logic cin, input logic [7:0] fin,
                           input logic [7:0] e_res, input logic [4:0] e_we, input logic [4:0] e_val,
                           input string tag);
        logic [17:0] got, exp;
        @(posedge clk);
        #1;
        op_sel = op; opa = a; opb = b; carry_in = cin; ccr_in = fin;
        @(negedge clk);
        got = {result, h_wr, n_wr, z_wr, v_wr, c_wr, h_nxt, n_nxt, z_nxt, v_nxt, c_nxt};
        exp = {e_res, e_we, e_val};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h cin=%b ccr=%h : got res=%h we=%b val=%b, expected res=%h we=%b val=%b",
                     tag, op, a, b, cin, fin, got[17:10], got[9:5], got[4:0], e_res, e_we, e_val);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cin, VECS[i].fin,
                    VECS[i].res, VECS[i].we, VECS[i].val, req_of(VECS[i].op));
        end

        // R1: ignored ccr bits 7,6,4 leave a logic op unchanged
        run_one(5'd6, 8'hFF, 8'h00, 1'b0, 8'hD0, 8'h00, 5'b01110, 5'b00100, "R1");
        // R13: load of zero raises Z with N low
        run_one(5'd10, 8'h00, 8'hAA, 1'b1, 8'h08, 8'h00, 5'b01110, 5'b00100, "R13");
        // R11: carry preset forces upper correction
        run_one(5'd21, 8'h12, 8'h00, 1'b0, 8'h01, 8'h72, 5'b01101, 5'b00001, "R11");

        // random sweep for every operation code
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < ((op < 22) ? RAND_PER : 4); k++) begin
                logic [7:0] a, b, f;
                logic       ci;
                logic [17:0] e;
                a  = 8'($urandom);
                b  = 8'($urandom);
                f  = 8'($urandom);
                ci = 1'($urandom);
                e  = ref_model(5'(op), a, b, ci, f);
                run_one(5'(op), a, b, ci, f, e[17:10], e[9:5], e[4:0], req_of(5'(op)));
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule